// File: doc/BRIEF.md
# Multiplexed Half-Word Burst Bus Controller

This block sequences the external bus of a 32-bit processor whose 16-bit data path shares the low address lines. An internal requester hands it one read or write of 1 to 16 bytes, or an instruction-fetch line request. The controller runs one address state, then one data state per half-word. Each data state is stretched by wait states until the memory answers with `ready`. The upper address half stays on `a_hi` for the whole burst. A dedicated three-bit index on `a_idx` steps through the half-words of the line.

The controller produces the address strobe (`ale`), the active-low address status (`as_n`), the write/read level, the active-low data enable (`den_n`) and the transfer direction (`dtr`). It also produces an output-enable for the shared lines (`ad_oe`) and one for every other bus output (`bus_oe`). Between two transactions there is always at least one idle cycle. An external master may take the bus with `hold`. The block grants it only from idle, acknowledges on `hlda` and floats its outputs.

Top module: `mbus_ctrl`

## Requirements
- R1: While `rst_n` is low and on the first cycle after, the bus is idle: `den_n`=1, `dtr`=1, `wr_rd`=1, `as_n`=1, `ale`=0, `hlda`=0, `ad_oe`=0, `bus_oe`=1, `req_ready`=1.
- R2: A request is accepted on a clock edge where `req_valid` and `req_ready` are both high. The next cycle is the address state, with these outputs:
  - `ale`=1, `as_n`=0, `den_n`=1 and `ad_oe`=1;
  - `ad_out` = request address bits 15:0;
  - `a_hi` = address bits 31:16.
- R3: The address state lasts exactly one cycle and is followed by a data state, in which `ale`=0, `as_n`=1 and `den_n`=0.
- R4: A data state completes only in a cycle where `ready` is 1, and `beat_ack` is high only then. While `ready` is 0 the controller stays in a wait state with `den_n`=0 and `a_idx` unchanged.
- R5: The burst length is determined by `req_len` (in bytes):
  - it holds ceil(`req_len`/2) data states;
  - a `req_len` of 0 or above 16 gives 8 data states;
  - `beat_last` marks the final beat.
- R6: `a_idx` starts at request address bits 3:1 and advances by one per completed beat, modulo 8. `a_hi` stays constant through the burst.
- R7: The transfer direction sets the data-state outputs:
  - for a write, `wr_rd`=1 and `dtr`=1, and in data states `ad_oe`=1 and `ad_out`=`wdata`;
  - for a read, `wr_rd`=0 and `dtr`=0, and in data states `ad_oe`=0, with `rd_valid`=1 and `rd_data`=`ad_in` when `beat_ack` is 1.
- R8: `dtr` and `wr_rd` never change between two consecutive cycles that both have `den_n`=0.
- R9: When `req_fetch`=1, the request is a read of 8 half-words starting at index 0, with address bits 3:0 driven as 0. `req_len` and `req_write` are ignored.
- R10: After the last beat, the next cycle is idle: `den_n`=1, `ale`=0, and `req_ready`=1 unless `hold` is high.
- R11: `hold` is honoured only from idle, where it takes priority over a request. The cycle after, `hlda`=1, `bus_oe`=0, `ad_oe`=0 and `ale`=0, and `req_ready` stays 0 while `hold` is high. A `hold` raised during a transaction waits until the burst and the following idle cycle are over.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| req_valid | input | 1 | Request present |
| req_write | input | 1 | 1 = write, 0 = read |
| req_fetch | input | 1 | Instruction line fetch (forces 8-beat read) |
| req_addr | input | 32 | Byte address of the request |
| req_len | input | 5 | Byte count 1..16 (0 or >16 means 16) |
| req_ready | output | 1 | Controller idle and able to accept |
| wdata | input | 16 | Write half-word for the current beat |
| beat_ack | output | 1 | Current data state completes this cycle |
| beat_last | output | 1 | Completing beat is the final one |
| rd_valid | output | 1 | Read half-word valid on rd_data |
| rd_data | output | 16 | Read half-word |
| hold | input | 1 | External bus request |
| hlda | output | 1 | Bus released to the external master |
| ready | input | 1 | Memory ready; low inserts a wait state |
| bus_oe | output | 1 | Enable for all control and address outputs |
| a_hi | output | 16 | Upper address half, valid all burst |
| a_idx | output | 3 | Half-word index within the line |
| ad_out | output | 16 | Shared address/data lines, outgoing value |
| ad_oe | output | 1 | Enable for ad_out |
| ad_in | input | 16 | Shared address/data lines, incoming value |
| ale | output | 1 | Address strobe, active high |
| as_n | output | 1 | Address status, active low |
| wr_rd | output | 1 | Write (1) / read (0) level |
| den_n | output | 1 | Data enable, active low |
| dtr | output | 1 | Direction: 1 transmit, 0 receive |

## Verification
The bench builds the block with its default parameters: a 32-bit address, a 16-bit data path, eight beats per line and a 5-bit length field. These defaults make both index wrap-around (a burst starting at index 4 or 6) and the clamp of oversized lengths reachable. With them, a full line, a one-beat and a two-beat request can all be driven in a single short run. Wait patterns of up to two cycles per beat are applied, and `hold` is raised both from idle and in the middle of a burst.

// File: rtl/mbus_pkg.sv
// Package: shared state encoding for the multiplexed burst bus controller.
// Assumes: nothing beyond IEEE 1800-2017.
package mbus_pkg;
    // Bus cycle states: idle, address, first data cycle, wait, released to master.
    typedef enum logic [2:0] {
        ST_IDLE = 3'd0,
        ST_ADDR = 3'd1,
        ST_DATA = 3'd2,
        ST_WAIT = 3'd3,
        ST_HOLD = 3'd4
    } bus_state_e;
endpackage

// File: rtl/mbus_seq.sv
// Module: bus cycle sequencer. Walks idle -> address -> data/wait ... -> idle,
// and grants hold only from idle. Assumes last_beat is valid in data states.
module mbus_seq
    import mbus_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       req_valid,
    input  logic       hold,
    input  logic       ready,
    input  logic       last_beat,
    output bus_state_e state,
    output logic       accept,
    output logic       beat_done,
    output logic       req_ready
);
    bus_state_e state_nx;
    logic       in_data;

    // Decode handshake and completion strobes from the current state.
    always_comb begin
        in_data   = (state == ST_DATA) || (state == ST_WAIT);
        req_ready = (state == ST_IDLE) && !hold;
        accept    = req_ready && req_valid;
        beat_done = in_data && ready;
    end

    // Next-state selection.
    always_comb begin
        state_nx = state;
        case (state)
            ST_IDLE: begin
                if (hold)           state_nx = ST_HOLD;
                else if (req_valid) state_nx = ST_ADDR;
            end
            ST_ADDR: state_nx = ST_DATA;
            ST_DATA, ST_WAIT: begin
                if (!ready)         state_nx = ST_WAIT;
                else if (last_beat) state_nx = ST_IDLE;
                else                state_nx = ST_DATA;
            end
            ST_HOLD: begin
                if (!hold)          state_nx = ST_IDLE;
            end
            default:                state_nx = ST_IDLE;
        endcase
    end

    // State register.
    always_ff @(posedge clk) begin
        if (!rst_n) state <= ST_IDLE;
        else        state <= state_nx;
    end

    p_addr_one_cycle_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_ADDR) |=> (state == ST_DATA));
    p_wait_inserted_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (in_data && !ready) |=> (state == ST_WAIT));
    p_idle_after_last_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (beat_done && last_beat) |=> (state == ST_IDLE));
    p_hold_from_idle_r11: assert property (@(posedge clk) disable iff (!rst_n)
        ((state == ST_HOLD) && ($past(state) != ST_HOLD)) |-> ($past(state) == ST_IDLE));
endmodule

// File: rtl/mbus_beat_cnt.sv
// Module: burst beat counter. Loads the beat count and start index on accept,
// steps once per completed beat. Assumes MAX_BEATS is a power of two.
module mbus_beat_cnt #(
    parameter int MAX_BEATS = 8,
    parameter int LEN_W     = 5,
    parameter int BPB       = 2,
    localparam int IDX_W     = $clog2(MAX_BEATS),
    localparam int CNT_W     = $clog2(MAX_BEATS + 1),
    localparam int HW_LSB    = $clog2(BPB),
    localparam int MAX_BYTES = MAX_BEATS * BPB
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load,
    input  logic             fetch,
    input  logic [LEN_W-1:0] req_len,
    input  logic [IDX_W-1:0] start_idx,
    input  logic             step,
    output logic [IDX_W-1:0] idx,
    output logic             last
);
    logic [LEN_W:0] len_up;
    logic [LEN_W:0] beats_w;
    logic [CNT_W-1:0] beats;
    logic [CNT_W-1:0] remain;

    // Round the byte count up to beats; zero or oversized means a full line.
    always_comb begin
        len_up  = {1'b0, req_len} + (LEN_W+1)'(BPB - 1);
        beats_w = len_up >> HW_LSB;
        if (fetch || (req_len == '0) || ({1'b0, req_len} > (LEN_W+1)'(MAX_BYTES)))
            beats = CNT_W'(MAX_BEATS);
        else
            beats = CNT_W'(beats_w);
        last = (remain == CNT_W'(1));
    end

    // Remaining-beat count and half-word index registers.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            remain <= '0;
            idx    <= '0;
        end else if (load) begin
            remain <= beats;
            idx    <= fetch ? '0 : start_idx;
        end else if (step) begin
            remain <= remain - 1'b1;
            idx    <= idx + 1'b1;
        end
    end

    p_step_nonempty_r5: assert property (@(posedge clk) disable iff (!rst_n)
        step |-> (remain != '0));
    p_idx_advance_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (step && !last && !load) |=> (idx == $past(idx) + 1'b1));
endmodule

// File: rtl/mbus_outdrv.sv
// Module: pin driver. Latches the request address and direction on accept and
// decodes strobes, enables and shared-line values from the state.
// Assumes DATA_W divides ADDR_W and the address state shows the latched address.
module mbus_outdrv
    import mbus_pkg::*;
#(
    parameter int ADDR_W = 32,
    parameter int DATA_W = 16,
    parameter int IDX_W  = 3,
    parameter int HW_LSB = 1,
    localparam int LINE_LSB = HW_LSB + IDX_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  bus_state_e        state,
    input  logic              accept,
    input  logic              beat_done,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic              req_write,
    input  logic              req_fetch,
    input  logic [IDX_W-1:0]  idx,
    input  logic [DATA_W-1:0] wdata,
    input  logic [DATA_W-1:0] ad_in,
    output logic              bus_oe,
    output logic              hlda,
    output logic              ale,
    output logic              as_n,
    output logic              wr_rd,
    output logic              den_n,
    output logic              dtr,
    output logic [ADDR_W-DATA_W-1:0] a_hi,
    output logic [IDX_W-1:0]  a_idx,
    output logic [DATA_W-1:0] ad_out,
    output logic              ad_oe,
    output logic              rd_valid,
    output logic [DATA_W-1:0] rd_data
);
    logic [ADDR_W-1:0] addr_q;
    logic              dir_q;
    logic              in_data;

    // Request latch: address (line-aligned for fetches) and direction.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            addr_q <= '0;
            dir_q  <= 1'b1;
        end else if (accept) begin
            addr_q <= req_fetch ? {req_addr[ADDR_W-1:LINE_LSB], {LINE_LSB{1'b0}}} : req_addr;
            dir_q  <= req_write && !req_fetch;
        end
    end

    // Strobe, enable and shared-line decode.
    always_comb begin
        in_data  = (state == ST_DATA) || (state == ST_WAIT);
        bus_oe   = (state != ST_HOLD);
        hlda     = (state == ST_HOLD);
        ale      = (state == ST_ADDR);
        as_n     = (state != ST_ADDR);
        den_n    = !in_data;
        wr_rd    = dir_q;
        dtr      = dir_q;
        a_hi     = addr_q[ADDR_W-1:DATA_W];
        a_idx    = idx;
        ad_out   = (state == ST_ADDR) ? addr_q[DATA_W-1:0] : wdata;
        ad_oe    = (state == ST_ADDR) || (in_data && dir_q);
        rd_valid = beat_done && !dir_q;
        rd_data  = ad_in;
    end

    p_ale_then_data_r3: assert property (@(posedge clk) disable iff (!rst_n)
        ale |=> (!ale && !den_n));
    p_dir_steady_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (!den_n && $past(!den_n)) |-> ($stable(dtr) && $stable(wr_rd)));
    p_upper_steady_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (!den_n && $past(!den_n)) |-> $stable(a_hi));
    p_hold_float_r11: assert property (@(posedge clk) disable iff (!rst_n)
        hlda |-> (!bus_oe && !ad_oe && !ale));
endmodule

// File: rtl/mbus_ctrl.sv
// Module: top of the multiplexed half-word burst bus controller. Connects the
// sequencer, the beat counter and the pin driver. Assumes requests do not need
// splitting at line boundaries (the index wraps within the line).
module mbus_ctrl #(
    parameter int ADDR_W    = 32,
    parameter int DATA_W    = 16,
    parameter int MAX_BEATS = 8,
    parameter int LEN_W     = 5,
    localparam int BPB    = DATA_W / 8,
    localparam int HW_LSB = $clog2(BPB),
    localparam int IDX_W  = $clog2(MAX_BEATS)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    input  logic              req_write,
    input  logic              req_fetch,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [LEN_W-1:0]  req_len,
    output logic              req_ready,
    input  logic [DATA_W-1:0] wdata,
    output logic              beat_ack,
    output logic              beat_last,
    output logic              rd_valid,
    output logic [DATA_W-1:0] rd_data,
    input  logic              hold,
    output logic              hlda,
    input  logic              ready,
    output logic              bus_oe,
    output logic [ADDR_W-DATA_W-1:0] a_hi,
    output logic [IDX_W-1:0]  a_idx,
    output logic [DATA_W-1:0] ad_out,
    output logic              ad_oe,
    input  logic [DATA_W-1:0] ad_in,
    output logic              ale,
    output logic              as_n,
    output logic              wr_rd,
    output logic              den_n,
    output logic              dtr
);
    mbus_pkg::bus_state_e state;
    logic             accept;
    logic             beat_done;
    logic             last;
    logic [IDX_W-1:0] idx;

    mbus_seq u_seq (
        .clk       (clk),
        .rst_n     (rst_n),
        .req_valid (req_valid),
        .hold      (hold),
        .ready     (ready),
        .last_beat (last),
        .state     (state),
        .accept    (accept),
        .beat_done (beat_done),
        .req_ready (req_ready)
    );

    mbus_beat_cnt #(
        .MAX_BEATS (MAX_BEATS),
        .LEN_W     (LEN_W),
        .BPB       (BPB)
    ) u_cnt (
        .clk       (clk),
        .rst_n     (rst_n),
        .load      (accept),
        .fetch     (req_fetch),
        .req_len   (req_len),
        .start_idx (req_addr[HW_LSB+IDX_W-1:HW_LSB]),
        .step      (beat_done),
        .idx       (idx),
        .last      (last)
    );

    mbus_outdrv #(
        .ADDR_W (ADDR_W),
        .DATA_W (DATA_W),
        .IDX_W  (IDX_W),
        .HW_LSB (HW_LSB)
    ) u_drv (
        .clk       (clk),
        .rst_n     (rst_n),
        .state     (state),
        .accept    (accept),
        .beat_done (beat_done),
        .req_addr  (req_addr),
        .req_write (req_write),
        .req_fetch (req_fetch),
        .idx       (idx),
        .wdata     (wdata),
        .ad_in     (ad_in),
        .bus_oe    (bus_oe),
        .hlda      (hlda),
        .ale       (ale),
        .as_n      (as_n),
        .wr_rd     (wr_rd),
        .den_n     (den_n),
        .dtr       (dtr),
        .a_hi      (a_hi),
        .a_idx     (a_idx),
        .ad_out    (ad_out),
        .ad_oe     (ad_oe),
        .rd_valid  (rd_valid),
        .rd_data   (rd_data)
    );

    // Beat strobes to the requester.
    always_comb begin
        beat_ack  = beat_done;
        beat_last = beat_done && last;
    end

    p_ack_needs_ready_r4: assert property (@(posedge clk) disable iff (!rst_n)
        beat_ack |-> (ready && !den_n));
endmodule

// File: tb/mbus_ctrl_bench.sv
// Bench: scoreboard of expected beats filled by the driver, drained by a monitor.
module mbus_ctrl_bench;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid = 1'b0, req_write = 1'b0, req_fetch = 1'b0;
    logic [31:0] req_addr = '0;
    logic [4:0]  req_len = '0;
    logic        req_ready;
    logic [15:0] wdata = '0;
    logic        beat_ack, beat_last, rd_valid;
    logic [15:0] rd_data;
    logic        hold = 1'b0, hlda, ready = 1'b0, bus_oe;
    logic [15:0] a_hi;
    logic [2:0]  a_idx;
    logic [15:0] ad_out;
    logic        ad_oe;
    logic [15:0] ad_in = '0;
    logic        ale, as_n, wr_rd, den_n, dtr;

    int n_chk = 0;
    int n_bad = 0;
    int beats_seen = 0;
    bit finished = 1'b0;

    typedef struct {
        logic [2:0]  idx;
        logic        wr;
        logic [15:0] data;
        logic [15:0] hi;
    } beat_t;
    beat_t sb[$];

    always #10 clk = ~clk;

    mbus_ctrl u_mbus_ctrl (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_write(req_write),
        .req_fetch(req_fetch), .req_addr(req_addr), .req_len(req_len),
        .req_ready(req_ready), .wdata(wdata), .beat_ack(beat_ack),
        .beat_last(beat_last), .rd_valid(rd_valid), .rd_data(rd_data),
        .hold(hold), .hlda(hlda), .ready(ready), .bus_oe(bus_oe), .a_hi(a_hi),
        .a_idx(a_idx), .ad_out(ad_out), .ad_oe(ad_oe), .ad_in(ad_in),
        .ale(ale), .as_n(as_n), .wr_rd(wr_rd), .den_n(den_n), .dtr(dtr)
    );

    task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    // Monitor: pops one expected beat per completed data state (R4 R5 R6 R7 R8).
    logic prev_den_low = 1'b0;
    logic prev_dtr = 1'b1;
    always begin
        @(negedge clk);
        #2;
        if (rst_n) begin
            if (!den_n && prev_den_low)
                chk(dtr == prev_dtr, "R8 dtr changed while data enabled", 32'(dtr), 32'(prev_dtr));
            if (beat_ack) begin
                if (sb.size() == 0) begin
                    chk(1'b0, "R5 extra beat", 32'(a_idx), 32'hFFFF_FFFF);
                end else begin
                    beat_t e;
                    e = sb.pop_front();
                    beats_seen++;
                    chk(a_idx == e.idx, "R6 beat index", 32'(a_idx), 32'(e.idx));
                    chk(a_hi == e.hi, "R6 upper address", 32'(a_hi), 32'(e.hi));
                    chk(wr_rd == e.wr && dtr == e.wr, "R7 direction", {wr_rd, dtr}, {e.wr, e.wr});
                    chk(den_n == 1'b0, "R4 data enable on ack", 32'(den_n), 32'd0);
                    if (e.wr) begin
                        chk(ad_oe && ad_out == e.data, "R7 write data", {ad_oe, ad_out}, {1'b1, e.data});
                    end else begin
                        chk(rd_valid && !ad_oe && rd_data == e.data, "R7 read data",
                            {ad_oe, rd_valid, rd_data}, {1'b0, 1'b1, e.data});
                    end
                    chk(beat_last == (sb.size() == 0), "R5 last beat flag",
                        32'(beat_last), 32'(sb.size() == 0));
                end
            end
            prev_den_low = !den_n;
            prev_dtr     = dtr;
        end
    end

    // Driver: issues one request, pushes expected beats, paces ready.
    task automatic xfer(input logic [31:0] addr, input logic [4:0] len, input logic wr,
                        input logic fetch, input int wmax, input int wseed, input bit hold_mid);
        int         nb;
        logic [2:0] st;
        logic       dir;
        logic [15:0] lo;
        int         seen0;
        nb  = (fetch || len == 0 || len > 16) ? 8 : (int'(len) + 1) / 2;
        st  = fetch ? 3'd0 : addr[3:1];
        dir = wr && !fetch;
        lo  = fetch ? {addr[15:4], 4'h0} : addr[15:0];
        for (int k = 0; k < nb; k++) begin
            beat_t b;
            b.idx = st + 3'(k);
            b.wr = dir;
            b.data = (addr[15:0] ^ 16'h5A00) + 16'(k);
            b.hi = addr[31:16];
            sb.push_back(b);
        end
        seen0 = beats_seen;
        @(negedge clk);
        req_valid = 1'b1; req_addr = addr; req_len = len; req_write = wr; req_fetch = fetch;
        #2 chk(req_ready == 1'b1, "R10 ready when idle", 32'(req_ready), 32'd1);
        @(negedge clk);
        req_valid = 1'b0;
        if (hold_mid) hold = 1'b1;
        #2;
        chk(ale && !as_n && den_n && ad_oe, "R2 address state strobes",
            {ale, as_n, den_n, ad_oe}, 4'b1011);
        chk(ad_out == lo, fetch ? "R9 fetch line address" : "R2 low address", 32'(ad_out), 32'(lo));
        chk(a_hi == addr[31:16], "R2 upper address", 32'(a_hi), 32'(addr[31:16]));
        for (int k = 0; k < nb; k++) begin
            int w;
            logic [15:0] d;
            w = (wmax == 0) ? 0 : (k + wseed) % (wmax + 1);
            d = (addr[15:0] ^ 16'h5A00) + 16'(k);
            for (int j = 0; j < w; j++) begin
                @(negedge clk);
                ready = 1'b0; wdata = d; ad_in = d;
                #2;
                chk(!beat_ack && !den_n && !ale && as_n, "R4 wait state",
                    {beat_ack, den_n, ale, as_n}, 4'b0001);
                chk(a_idx == st + 3'(k), "R4 index held in wait", 32'(a_idx), 32'(st + 3'(k)));
                if (hold_mid) chk(!hlda, "R11 hold deferred", 32'(hlda), 32'd0);
            end
            @(negedge clk);
            ready = 1'b1; wdata = d; ad_in = d;
            if (k == 0) begin
                #2 chk(!ale && as_n && !den_n, "R3 first data state", {ale, as_n, den_n}, 3'b010);
            end
        end
        @(negedge clk);
        ready = 1'b0;
        #2;
        chk(beats_seen - seen0 == nb, "R5 beat count", 32'(beats_seen - seen0), 32'(nb));
        chk(den_n && !ale && !hlda, "R10 idle after last", {den_n, ale, hlda}, 3'b100);
        chk(req_ready == !hold_mid, "R10 ready after burst", 32'(req_ready), 32'(!hold_mid));
        if (hold_mid) begin
            @(negedge clk);
            #2 chk(hlda && !bus_oe && !ad_oe, "R11 hold granted after idle",
                   {hlda, bus_oe, ad_oe}, 3'b100);
            @(negedge clk);
            hold = 1'b0;
            @(negedge clk);
            #2 chk(!hlda && req_ready, "R11 hold released", {hlda, req_ready}, 2'b01);
        end
    endtask

    initial begin
        repeat (3) @(negedge clk);
        #2;
        chk(den_n && dtr && wr_rd && as_n && !ale && !hlda && !ad_oe && bus_oe && req_ready,
            "R1 reset state", {den_n, dtr, wr_rd, as_n, ale, hlda, ad_oe, bus_oe, req_ready},
            9'b111100011);
        @(negedge clk);
        rst_n = 1'b1;
        #2 chk(den_n && dtr && !ale, "R1 first cycle after reset", {den_n, dtr, ale}, 3'b110);

        xfer(32'h1234_5672, 5'd4, 1'b1, 1'b0, 0, 0, 1'b0);   // R2 R7 write, 2 beats
        xfer(32'h8000_0000, 5'd16, 1'b0, 1'b0, 2, 1, 1'b0);  // R4 R5 read line with waits
        xfer(32'hABCD_00EC, 5'd3, 1'b0, 1'b0, 1, 0, 1'b0);   // R5 odd length, idx 6..7
        xfer(32'h0000_0108, 5'd16, 1'b1, 1'b0, 1, 1, 1'b0);  // R6 wrap 4..3
        xfer(32'h4000_123A, 5'd1, 1'b1, 1'b1, 0, 0, 1'b0);   // R9 fetch overrides
        xfer(32'h0000_0000, 5'd0, 1'b1, 1'b0, 2, 2, 1'b0);   // R5 zero length = full
        xfer(32'h00FF_0004, 5'd20, 1'b0, 1'b0, 0, 0, 1'b0);  // R5 oversized = full
        xfer(32'h7777_0006, 5'd1, 1'b0, 1'b0, 2, 1, 1'b1);   // R11 hold mid-burst

        // R11: hold from idle beats a simultaneous request.
        @(negedge clk);
        hold = 1'b1; req_valid = 1'b1; req_write = 1'b1; req_fetch = 1'b0;
        req_addr = 32'h5555_0000; req_len = 5'd2;
        #2 chk(!req_ready, "R11 not ready under hold", 32'(req_ready), 32'd0);
        @(negedge clk);
        #2 chk(hlda && !bus_oe && !ad_oe && !ale, "R11 bus floated",
               {hlda, bus_oe, ad_oe, ale}, 4'b1000);
        @(negedge clk);
        hold = 1'b0; req_valid = 1'b0;
        #2 chk(hlda, "R11 still held", 32'(hlda), 32'd1);
        @(negedge clk);
        #2 chk(!hlda && !ale && req_ready && sb.size() == 0, "R11 request ignored while held",
               {hlda, ale, req_ready}, 3'b001);

        finished = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!finished) begin
            n_bad++;
            $display("FAIL watchdog (all requirements) actual=%0d expected=done", n_chk);
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end
endmodule